// File: doc/BRIEF.md
# Registered Logic Output Cell with Test Load and Pattern Lock

This block is the registered output stage of one cell in a small programmable-logic array. A single flip-flop captures the product-term sum `sop_in` on each rising clock edge. The pin value is the stored state, optionally inverted by one bit of the cell's configuration pattern. The flip-flop has a synchronous set, an asynchronous clear and a power-on clear. All three act on the stored state, and the pin follows through the selected polarity.

For functional test, a load path forces any value from the pin side into the flip-flop, so states that the logic can never reach can be set up directly. A small configuration store holds the cell's pattern bits and a lock bit. While the lock bit is set, readback of the pattern shows every bit as erased and the test load is refused. The lock bit is cleared only by an erase of the whole pattern. Writing a new pattern erases the old one as part of the same write.

Top module: `lmc_top`

## Requirements
- R1: While `por` is high the flip-flop holds 0 asynchronously, and the pin shows 0 passed through the selected polarity.
- R2: With no clear, set or accepted load, the flip-flop takes `sop_in` on each rising edge of `clk`.
- R3: `pin` equals the stored state XOR an invert flag. The invert flag is 1 when pattern bit `POL_BIT` (default bit 0) is 0 (programmed), and 0 when that bit is 1 (erased).
- R4: `clr_async` clears the flip-flop at once, without waiting for a clock edge, and wins over `set_sync` for as long as it is high.
- R5: `set_sync` sets the flip-flop to 1 on the next rising edge and wins over both the test load and `sop_in`.
- R6: When `pl_en` is high and the lock bit is clear, the next rising edge stores `pl_data` in place of `sop_in`.
- R7: While the lock bit is set, `rd_pat` reads all ones (every bit erased), whatever the stored pattern.
- R8: While the lock bit is set, `pl_en` has no effect and the flip-flop keeps following `sop_in`.
- R9: `lock_set` sets the lock bit on a rising edge. Power-on clear, set and clear of the flip-flop leave the lock bit unchanged; only an erase or a pattern write clears it.
- R10: `prog_en` writes `prog_pat` into the pattern on a rising edge, with no erase needed first, and clears the lock bit.
- R11: `erase_en` sets every pattern bit to 1 and clears the lock bit on a rising edge. Erase wins over a pattern write, and a pattern write wins over `lock_set`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| por | input | 1 | Power-on clear of the flip-flop, active high, asynchronous |
| sop_in | input | 1 | Sum-of-products next-state value |
| set_sync | input | 1 | Synchronous set of the flip-flop |
| clr_async | input | 1 | Asynchronous clear of the flip-flop |
| pl_en | input | 1 | Test load request |
| pl_data | input | 1 | Value to load from the pin side |
| prog_en | input | 1 | Write `prog_pat` into the pattern |
| prog_pat | input | PAT_W | New pattern bits (0 = programmed) |
| lock_set | input | 1 | Set the lock bit |
| erase_en | input | 1 | Erase the whole pattern and the lock bit |
| rd_pat | output | PAT_W | Pattern readback, masked to all ones while locked |
| pin | output | 1 | Output pin level |

## Verification
The next-state path is driven with `sop_in` toggled under both polarities, so that a missing or wrong inversion shows up at the pin. Collisions are then set up: clear with set, set with load and an opposing `sop_in`, and load with an opposing `sop_in`. Each collision has only one correct winner under the priority order. The test load is tried with the lock off, on, and off again after an erase, with `pl_data` always opposite to `sop_in`, which tells a refused load from an accepted one. Readback is checked after a write with no erase first, after locking, after a power-on clear while locked, and after a write that drops the lock.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

    // Source of the flip-flop's next value on a clock edge
    typedef enum logic [1:0] {
        SRC_SOP     = 2'd0,
        SRC_SET     = 2'd1,
        SRC_PRELOAD = 2'd2
    } src_e;

    typedef struct packed {
        logic state;
    } ff_t;

endpackage

// File: rtl/lmc_cfg_store.sv
module lmc_cfg_store #(
    parameter int PAT_W = 8
) (
    input  logic             clk,
    input  logic             por,
    input  logic             prog_en,
    input  logic [PAT_W-1:0] prog_pat,
    input  logic             lock_set,
    input  logic             erase_en,
    output logic [PAT_W-1:0] pat,
    output logic             lock
);

    localparam logic [PAT_W-1:0] ERASED = {PAT_W{1'b1}};

    typedef struct packed {
        logic [PAT_W-1:0] pat;
        logic             lock;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    // Configuration is non-volatile: it has no reset, only explicit erase
    always_comb begin
        cfg_d = cfg_q;
        if (erase_en) begin
            cfg_d.pat  = ERASED;
            cfg_d.lock = 1'b0;
        end else if (prog_en) begin
            cfg_d.pat  = prog_pat;   // write includes its own erase
            cfg_d.lock = 1'b0;
        end else if (lock_set) begin
            cfg_d.lock = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign pat  = cfg_q.pat;
    assign lock = cfg_q.lock;

    AST_ERASE_ALL_ONES: assert property (@(posedge clk) disable iff (por)
        erase_en |=> (pat == ERASED) && !lock); // R11

    AST_LOCK_HOLD: assert property (@(posedge clk)
        (lock && !erase_en && !prog_en) |=> lock); // R9

    AST_PROG_WRITE: assert property (@(posedge clk) disable iff (por)
        (prog_en && !erase_en) |=> (pat == $past(prog_pat)) && !lock); // R10

endmodule

// File: rtl/lmc_ff.sv
module lmc_ff
    import lmc_pkg::*;
(
    input  logic clk,
    input  logic por,
    input  logic clr_async,
    input  logic set_sync,
    input  logic pl_ok,
    input  logic pl_data,
    input  logic sop_in,
    output logic state
);

    ff_t  ff_d, ff_q;
    src_e src;
    logic clr_any;

    assign clr_any = por | clr_async;

    always_comb begin
        if (set_sync)
            src = SRC_SET;
        else if (pl_ok)
            src = SRC_PRELOAD;
        else
            src = SRC_SOP;

        ff_d = ff_q;
        unique case (src)
            SRC_SET:     ff_d.state = 1'b1;
            SRC_PRELOAD: ff_d.state = pl_data;
            default:     ff_d.state = sop_in;
        endcase
    end

    always_ff @(posedge clk or posedge clr_any) begin
        if (clr_any)
            ff_q <= '0;
        else
            ff_q <= ff_d;
    end

    assign state = ff_q.state;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (clr_any)
        set_sync |=> state); // R5

    AST_PRELOAD_TAKES: assert property (@(posedge clk) disable iff (clr_any)
        (!set_sync && pl_ok) |=> (state == $past(pl_data))); // R6

    AST_SOP_FOLLOW: assert property (@(posedge clk) disable iff (clr_any)
        (!set_sync && !pl_ok) |=> (state == $past(sop_in))); // R2

endmodule

// File: rtl/lmc_top.sv
module lmc_top #(
    parameter int PAT_W   = 8,
    parameter int POL_BIT = 0
) (
    input  logic             clk,
    input  logic             por,
    input  logic             sop_in,
    input  logic             set_sync,
    input  logic             clr_async,
    input  logic             pl_en,
    input  logic             pl_data,
    input  logic             prog_en,
    input  logic [PAT_W-1:0] prog_pat,
    input  logic             lock_set,
    input  logic             erase_en,
    output logic [PAT_W-1:0] rd_pat,
    output logic             pin
);

    localparam logic [PAT_W-1:0] ERASED = {PAT_W{1'b1}};

    logic [PAT_W-1:0] pat;
    logic             lock;
    logic             state;
    logic             pl_ok;
    logic             invert;

    lmc_cfg_store #(.PAT_W(PAT_W)) u_cfg (
        .clk      (clk),
        .por      (por),
        .prog_en  (prog_en),
        .prog_pat (prog_pat),
        .lock_set (lock_set),
        .erase_en (erase_en),
        .pat      (pat),
        .lock     (lock)
    );

    assign pl_ok = pl_en & ~lock;

    lmc_ff u_ff (
        .clk       (clk),
        .por       (por),
        .clr_async (clr_async),
        .set_sync  (set_sync),
        .pl_ok     (pl_ok),
        .pl_data   (pl_data),
        .sop_in    (sop_in),
        .state     (state)
    );

    // Programmed (0) polarity bit selects the inverting output
    assign invert = ~pat[POL_BIT];
    assign pin    = state ^ invert;
    assign rd_pat = lock ? ERASED : pat;

    AST_LOCK_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (por || clr_async)
        (lock && pl_en && !set_sync) |=> (state == $past(sop_in))); // R8

    AST_LOCK_MASKS_READ: assert property (@(posedge clk)
        lock |-> (rd_pat == ERASED)); // R7

endmodule

// File: tb/sim_lmc_top.sv
module sim_lmc_top;

    localparam int PAT_W = 8;

    logic             clk = 1'b0;
    logic             por, sop_in, set_sync, clr_async, pl_en, pl_data;
    logic             prog_en, lock_set, erase_en;
    logic [PAT_W-1:0] prog_pat;
    logic [PAT_W-1:0] rd_pat;
    logic             pin;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    lmc_top #(.PAT_W(PAT_W), .POL_BIT(0)) u0 (
        .clk(clk), .por(por), .sop_in(sop_in), .set_sync(set_sync),
        .clr_async(clr_async), .pl_en(pl_en), .pl_data(pl_data),
        .prog_en(prog_en), .prog_pat(prog_pat), .lock_set(lock_set),
        .erase_en(erase_en), .rd_pat(rd_pat), .pin(pin)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk_pin(string req, logic exp);
        checks++;
        if (pin !== exp) begin
            errors++;
            $display("FAIL %s pin actual %b expected %b", req, pin, exp);
        end
    endtask

    task automatic chk_rd(string req, logic [PAT_W-1:0] exp);
        checks++;
        if (rd_pat !== exp) begin
            errors++;
            $display("FAIL %s rd_pat actual %h expected %h", req, rd_pat, exp);
        end
    endtask

    task automatic t_reset();
        por = 1; sop_in = 1; set_sync = 0; clr_async = 0; pl_en = 0; pl_data = 0;
        prog_en = 0; prog_pat = '0; lock_set = 0; erase_en = 1;
        step(); step();
        erase_en = 0;
        chk_pin("R1", 1'b0);          // erased pattern, non-inverting
        chk_rd("R11", 8'hFF);
        prog_en = 1; prog_pat = 8'hFE; // bit0 programmed: inverting
        step();
        prog_en = 0;
        chk_pin("R1", 1'b1);          // state low, inverted to high
        chk_rd("R10", 8'hFE);
        step();
        chk_pin("R1", 1'b1);          // sop_in=1 ignored under por
        por = 0;
    endtask

    task automatic t_normal();
        sop_in = 1; step();
        chk_pin("R2", 1'b0);          // r3_ inverted
        sop_in = 0; step();
        chk_pin("R3", 1'b1);
        prog_en = 1; prog_pat = 8'hA5; step(); // no erase first
        prog_en = 0;
        chk_rd("R10", 8'hA5);
        sop_in = 1; step();
        chk_pin("R2", 1'b1);          // non-inverting now
    endtask

    task automatic t_async();
        sop_in = 1; step();
        clr_async = 1; set_sync = 1; #1;
        chk_pin("R4", 1'b0);          // no clock edge yet
        step();
        chk_pin("R4", 1'b0);          // clear wins over set
        clr_async = 0; set_sync = 0;
    endtask

    task automatic t_set();
        sop_in = 0; pl_en = 1; pl_data = 0; set_sync = 1; step();
        chk_pin("R5", 1'b1);
        set_sync = 0; pl_en = 0;
    endtask

    task automatic t_preload();
        sop_in = 0; pl_en = 1; pl_data = 1; step();
        chk_pin("R6", 1'b1);
        sop_in = 1; pl_data = 0; step();
        chk_pin("R6", 1'b0);
        pl_en = 0;
    endtask

    task automatic t_lock();
        lock_set = 1; step();
        lock_set = 0;
        chk_rd("R7", 8'hFF);
        pl_en = 1; pl_data = 1; sop_in = 0; step();
        chk_pin("R8", 1'b0);
        pl_data = 0; sop_in = 1; step();
        chk_pin("R8", 1'b1);
        pl_en = 0;
        por = 1; step(); por = 0;
        chk_rd("R9", 8'hFF);          // lock kept across power-on clear
        set_sync = 1; step(); set_sync = 0;
        pl_en = 1; pl_data = 0; sop_in = 1; step();
        chk_pin("R9", 1'b1);          // load still refused
        pl_en = 0;
    endtask

    task automatic t_erase();
        erase_en = 1; step(); erase_en = 0;
        chk_rd("R11", 8'hFF);
        pl_en = 1; pl_data = 1; sop_in = 0; step();
        chk_pin("R9", 1'b1);          // lock gone, load accepted
        pl_en = 0;
        prog_en = 1; prog_pat = 8'h3C; step(); prog_en = 0;
        chk_rd("R10", 8'h3C);
        lock_set = 1; step(); lock_set = 0;
        chk_rd("R7", 8'hFF);
        prog_en = 1; prog_pat = 8'h5B; lock_set = 1; step();
        prog_en = 0; lock_set = 0;
        chk_rd("R11", 8'h5B);         // write wins over lock_set, clears lock
    endtask

    initial begin
        t_reset();
        t_normal();
        t_async();
        t_set();
        t_preload();
        t_lock();
        t_erase();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule